// File: doc/BRIEF.md
# Power-Management Counter with Event Status and Interrupt

This block keeps a free-running power-management counter next to a pair of 16-bit event registers, one holding status flags and one holding their enables. Whenever the counter's top bit changes, in either direction, a timer flag is latched into the status register. Two further flags, power button and global, are latched from dedicated set inputs. A single level interrupt output is high while any of these three flags is both latched and enabled.

Software reaches the block through a byte-addressed register port. Each access is 1, 2 or 4 bytes wide and targets one of two 4-byte windows. The event window holds status at offsets 0..1 and enable at offsets 2..3. The counter window is read-only. A tick-enable input advances the counter. The read data path is combinational and is valid in the same cycle as the read request. Writes take effect at the next clock edge.

Top module: `pm_event_timer`

## Requirements
- R1: The counter is CNT_WIDTH bits wide (32 by default). It adds one on each clock edge where `tick` is high, holds otherwise, and wraps modulo 2^CNT_WIDTH.
- R2: When a tick changes the counter's most significant bit, from 0 to 1 or from 1 to 0, status bit 0 (timer flag) is set on that edge.
- R3: A high `pwrbtn_set` sets status bit 5 and a high `global_set` sets status bit 8. A set, or a timer flip, wins over a clearing write to the same bit in the same cycle. Status bits other than 0, 5 and 8 always read 0.
- R4: `sci` is high exactly when at least one of bits 0, 5, 8 is set in both status and enable. It follows the registers written or set at the previous edge, with no further delay.
- R5: Status is write-one-to-clear. A written byte at event offset 0 clears the status bits 7:0 where the data is 1. A byte at offset 1 does the same for bits 15:8. Zero data bits leave their status bits unchanged.
- R6: Enable is 16 bits, fully writable and readable. A byte at event offset 2 replaces enable bits 7:0 and a byte at offset 3 replaces bits 15:8. The other byte is kept.
- R7: A read of the event window returns {enable, status} as a 32-bit word, shifted right by 8 × offset and zero-filled. It is then truncated to 8 bits for size code 0, to 16 bits for size code 1, and left whole for size codes 2 and 3. Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 4 bytes.
- R8: Writes to the counter window (`bus_win`=1) change nothing. A 4-byte read at offset 0 returns the counter, zero-extended. Any other read of that window returns 0.
- R9: After reset, the counter, status and enable are all zero and `sci` is low.
- R10: In a write, data byte j (bits 8j+7:8j) goes to window offset `bus_off`+j. Bytes that would land beyond offset 3 are dropped.
- R11: `bus_rdata` is 0 whenever no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance enable |
| pwrbtn_set | input | 1 | Sets power-button status flag |
| global_set | input | 1 | Sets global status flag |
| bus_en | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 0 = event window, 1 = counter window |
| bus_off | input | 2 | Byte offset inside the window |
| bus_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| bus_wdata | input | 32 | Write data, byte j to offset+j |
| bus_rdata | output | 32 | Read data, same cycle |
| sci | output | 1 | Level interrupt |

## Verification
A wrong status or enable bit shows on `sci` one clock after the write or set that produced it. The same bit shows on a read of the event window in any later cycle. A lost or doubled timer flip is visible as a status bit 0 that disagrees with the count read back around the top-bit crossing. The bench therefore compares `sci` every cycle and every read against a register model. It runs a narrowed counter so that both crossing directions occur many times.

// File: rtl/pm_event_timer.sv
module pm_event_timer #(
  parameter int CNT_WIDTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        pwrbtn_set,
  input  logic        global_set,
  input  logic        bus_en,
  input  logic        bus_wr,
  input  logic        bus_win,
  input  logic [1:0]  bus_off,
  input  logic [1:0]  bus_size,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sci
);
  localparam logic [15:0] FLAG_MASK = 16'h0121;
  localparam int          MSB       = CNT_WIDTH - 1;

  logic [MSB:0] cnt;
  logic [15:0]  sts, en;

  logic         wr_evt, flip;
  logic [3:0]   len_mask;
  logic [3:0]   lane_hit;
  logic [7:0]   lane_sh;
  logic [31:0]  wshift;
  logic [15:0]  clr, set_bits;
  logic [31:0]  evt_word, evt_rd, cnt_rd;

  assign wr_evt   = bus_en && bus_wr && !bus_win;
  assign flip     = tick && (&cnt[MSB-1:0]);
  assign len_mask = (bus_size == 2'd0) ? 4'b0001 : (bus_size == 2'd1) ? 4'b0011 : 4'b1111;
  assign lane_sh  = {4'b0000, len_mask} << bus_off;
  assign lane_hit = wr_evt ? lane_sh[3:0] : 4'b0000;
  assign wshift   = bus_wdata << {bus_off, 3'b000};

  assign clr      = {lane_hit[1] ? wshift[15:8] : 8'h00, lane_hit[0] ? wshift[7:0] : 8'h00};
  assign set_bits = {7'b0, global_set, 2'b0, pwrbtn_set, 4'b0, flip};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sts <= '0;
      en  <= '0;
    end else begin
      if (tick) cnt <= cnt + 1'b1;
      sts <= ((sts & ~clr) | set_bits) & FLAG_MASK;
      if (lane_hit[2]) en[7:0]  <= wshift[23:16];
      if (lane_hit[3]) en[15:8] <= wshift[31:24];
    end
  end

  assign evt_word = {en, sts} >> {bus_off, 3'b000};
  assign evt_rd   = (bus_size == 2'd0) ? {24'h0, evt_word[7:0]} :
                    (bus_size == 2'd1) ? {16'h0, evt_word[15:0]} : evt_word;
  assign cnt_rd   = (bus_off == 2'd0 && bus_size[1]) ? 32'(cnt) : 32'h0;

  assign bus_rdata = (bus_en && !bus_wr) ? (bus_win ? cnt_rd : evt_rd) : 32'h0;
  assign sci       = |(sts & en & FLAG_MASK);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_flip_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&cnt[MSB-1:0])) |=> sts[0]);

  assert_pwr_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwrbtn_set |=> sts[5]);

  assert_glb_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    global_set |=> sts[8]);

  assert_sci_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sci) |-> ($past(wr_evt) || $past(flip) || $past(pwrbtn_set) || $past(global_set)));

  assert_cnt_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && bus_win && !tick) |=> $stable(cnt));

  assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && !bus_wr) |-> bus_rdata == 32'h0);
endmodule

// File: tb/pm_event_timer_bench.sv
module pm_event_timer_bench;
  localparam int W = 10;

  logic clk = 0, rst_n = 0;
  logic tick = 0, pwrbtn_set = 0, global_set = 0;
  logic bus_en = 0, bus_wr = 0, bus_win = 0;
  logic [1:0] bus_off = 0, bus_size = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic sci;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [W-1:0] m_cnt = '0;
  logic [15:0]  m_sts = '0, m_en = '0;

  always #5 clk = ~clk;

  pm_event_timer #(.CNT_WIDTH(W)) u_pm_event_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwrbtn_set(pwrbtn_set),
    .global_set(global_set), .bus_en(bus_en), .bus_wr(bus_wr), .bus_win(bus_win),
    .bus_off(bus_off), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sci(sci));

  function automatic logic [31:0] exp_read(logic win, logic [1:0] off, logic [1:0] size);
    logic [31:0] v;
    if (win) return (off == 0 && size >= 2) ? 32'(m_cnt) : 32'h0;
    v = {m_en, m_sts} >> (8 * off);
    if (size == 0) v &= 32'hff;
    else if (size == 1) v &= 32'hffff;
    return v;
  endfunction

  function automatic logic exp_sci();
    return |(m_sts & m_en & 16'h0121);
  endfunction

  task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [15:0] clr = 0;
    int len = (bus_size == 0) ? 1 : (bus_size == 1) ? 2 : 4;
    logic fl = tick && (&m_cnt[W-2:0]);
    if (bus_en && bus_wr && !bus_win)
      for (int j = 0; j < len; j++) begin
        int a = bus_off + j;
        logic [7:0] b = bus_wdata[8*j +: 8];
        if (a == 0) clr[7:0] = b;
        else if (a == 1) clr[15:8] = b;
        else if (a == 2) m_en[7:0] = b;
        else if (a == 3) m_en[15:8] = b;
      end
    m_sts = m_sts & ~clr;
    if (fl) m_sts[0] = 1;
    if (pwrbtn_set) m_sts[5] = 1;
    if (global_set) m_sts[8] = 1;
    m_sts &= 16'h0121;
    if (tick) m_cnt = m_cnt + 1'b1;
  endtask

  task automatic step(logic t, logic ps, logic gs, logic e, logic w, logic win,
                      logic [1:0] off, logic [1:0] size, logic [31:0] wd, string tag);
    @(negedge clk);
    tick = t; pwrbtn_set = ps; global_set = gs;
    bus_en = e; bus_wr = w; bus_win = win; bus_off = off; bus_size = size; bus_wdata = wd;
    #1;
    chk(sci === exp_sci(), "R4 sci", 32'(sci), 32'(exp_sci()));
    if (e && !w) chk(bus_rdata === exp_read(win, off, size), tag, bus_rdata, exp_read(win, off, size));
    else chk(bus_rdata === 32'h0, "R11 idle rdata", bus_rdata, 32'h0);
    model_step();
  endtask

  task automatic rd(logic win, logic [1:0] off, logic [1:0] size, string tag);
    step(0, 0, 0, 1, 0, win, off, size, 32'h0, tag);
  endtask

  task automatic wr(logic win, logic [1:0] off, logic [1:0] size, logic [31:0] d);
    step(0, 0, 0, 1, 1, win, off, size, d, "wr");
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, 0, 2, "R9 event reset");
    rd(1, 0, 2, "R9 counter reset");
    wr(0, 3, 0, 32'h0000_00a5);
    rd(0, 2, 1, "R6 enable high byte");
    wr(0, 2, 0, 32'h0000_003c);
    rd(0, 2, 1, "R6 enable low byte kept high");
    wr(0, 2, 2, 32'h5678_1234);
    rd(0, 2, 1, "R10 lanes beyond window dropped");
    rd(0, 3, 0, "R7 byte read offset 3");
    repeat (37) step(1, 0, 0, 0, 0, 0, 0, 0, 0, "");
    rd(1, 0, 2, "R1 counter after 37 ticks");
    wr(1, 0, 2, 32'hffff_ffff);
    rd(1, 0, 2, "R8 counter write ignored");
    rd(1, 0, 1, "R8 short counter read zero");
    rd(1, 1, 2, "R8 offset counter read zero");
    wr(0, 2, 1, 32'h0000_0121);
    while (m_cnt != (1 << (W-1)) - 1) step(1, 0, 0, 0, 0, 0, 0, 0, 0, "");
    rd(0, 0, 1, "R2 no flag before crossing");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "");
    rd(0, 0, 1, "R2 flag on rising top bit");
    wr(0, 0, 0, 32'h0000_0001);
    rd(0, 0, 1, "R5 clear timer flag");
    while (m_cnt != {W{1'b1}}) step(1, 0, 0, 0, 0, 0, 0, 0, 0, "");
    step(1, 0, 0, 1, 1, 0, 0, 0, 32'h1, "R3 flip beats clear");
    rd(0, 0, 1, "R3 timer flag kept");
    rd(1, 0, 3, "R1 wrapped counter");
    step(0, 1, 1, 1, 1, 0, 0, 1, 32'h0000_0120, "R3 set beats clear");
    rd(0, 0, 1, "R3 set wins");
    wr(0, 1, 0, 32'h0000_0001);
    rd(0, 0, 1, "R5 high lane clear");
    wr(0, 0, 1, 32'h0000_0020);
    rd(0, 0, 2, "R5 low lane clear");
    wr(0, 0, 1, 32'h0000_ffff);
    wr(0, 2, 1, 32'h0000_0000);
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, "");
    rd(0, 0, 1, "R4 flag set but disabled");
    wr(0, 2, 0, 32'h0000_0020);
    rd(0, 0, 2, "R4 enabled flag raises sci");
    wr(0, 0, 0, 32'h0000_0020);
    rd(0, 1, 0, "R7 byte read offset 1");
    for (int i = 0; i < 6000; i++) begin
      logic e = ($urandom % 3) != 0;
      step(($urandom % 4) != 0, ($urandom % 23) == 0, ($urandom % 29) == 0,
           e, ($urandom % 2) == 1, ($urandom % 4) == 0, 2'($urandom), 2'($urandom),
           $urandom, "R7 random read");
    end
    rd(0, 0, 2, "R7 final event read");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule